// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Timing Controller

This block is a cycle-level timing model of a single DRAM bank with one row buffer. Read requests arrive over a valid/ready handshake and carry a row address, a column address and a tag. When a request is accepted, the block checks it against the row buffer. The access is a hit when the requested row is already open. It is an empty access when no row is open. It is a conflict when a different row is open. The block then counts the latency that matches that case. When the count ends, it reports completion with a one-cycle pulse that carries the request's tag and column, together with the access class.

A static policy input selects how the row buffer is handled after each access. Under open-page policy the row stays open after the access. Under close-page policy a precharge starts as soon as each access completes, and the bank accepts nothing until that precharge is over. Requests are served strictly in arrival order. One latency unit is a parameter measured in clock cycles. With one cycle per unit and a 10 ns clock, finish times can be read directly in nanoseconds.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset, `req_ready_o` is high and `done_o` is low. The bank starts precharged, so the first accepted request is an empty access.
- R2: An empty access raises `done_o` exactly 4 units after the clock edge that accepts it. Both class outputs are low with that pulse.
- R3: A hit raises `done_o` exactly 2 units after acceptance, with `done_hit_o` high and `done_conf_o` low.
- R4: A conflict raises `done_o` exactly 6 units after acceptance, with `done_conf_o` high and `done_hit_o` low.
- R5: Under open-page policy (`close_page_i` low), the row of the last access stays open. A later request to that same row is a hit, and a request to any other row is a conflict.
- R6: Under close-page policy (`close_page_i` high), a 2-unit precharge follows each completion. During that precharge `req_ready_o` stays low. Every access under this policy is an empty access.
- R7: Requests complete in acceptance order. A request that has been waiting is accepted on the edge where the previous work ends: the completion edge under open-page policy, or the edge that ends the precharge under close-page policy. No idle cycle is added.
- R8: `done_o` is a one-cycle pulse. `done_tag_o` and `done_col_o` carry the tag and column of the request that is completing.
- R9: `req_ready_o` is low from the cycle after an acceptance until that access finishes. Each accepted request produces exactly one completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| close_page_i | input | 1 | Static policy select: 1 = close-page, 0 = open-page |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Bank can accept a request this cycle |
| req_row_i | input | ROW_W | Request row address |
| req_col_i | input | COL_W | Request column address |
| req_tag_i | input | TAG_W | Request tag |
| done_o | output | 1 | One-cycle completion pulse |
| done_tag_o | output | TAG_W | Tag of the completing request |
| done_col_o | output | COL_W | Column of the completing request |
| done_hit_o | output | 1 | Completing access was a row-buffer hit |
| done_conf_o | output | 1 | Completing access was a row conflict |

## Verification
The hardest case to reach from the ports is a request that is already waiting when the bank frees up. It must be accepted on that exact edge and classified against the row state as it will be, not as it is. Under open-page policy the waiting request sees the row just opened. Under close-page policy it sees an empty buffer, even though the precharge is only ending on that same edge. The stimulus produces these cases with an arrival pattern at 0, 10, 100, 200, 250 and 300 ns. Two rows of the same bank are interleaved in that pattern, and requests arrive while earlier accesses and precharges are still running. The same pattern is run under both policies, and each finish time is compared with its hand-computed value. Directed tests add a back-to-back hit and probe the ready signal on the cycles around a precharge.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    ACC_EMPTY = 2'd0,
    ACC_HIT   = 2'd1,
    ACC_CONF  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_PRECH  = 2'd2
  } bank_st_e;
endpackage

// File: rtl/dbt_row_tracker.sv
module dbt_row_tracker
  import dbt_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,        // row activated by accepted request
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,       // precharge finished
  input  logic             force_empty_i, // precharge in flight: row is going away
  output acc_kind_e        kind_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  always_comb begin
    if (!open_q || force_empty_i) kind_o = ACC_EMPTY;
    else if (row_q == row_i)      kind_o = ACC_HIT;
    else                          kind_o = ACC_CONF;
  end

  AST_CLOSED_IS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !open_i) |=> (kind_o == ACC_EMPTY)); // R6

endmodule

// File: rtl/dbt_cycle_counter.sv
module dbt_cycle_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // a new interval may only start once the running one has expired
  AST_LOAD_WHEN_EXPIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o); // R7

endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int TAG_W    = 4,
  parameter int UNIT_CYC = 4, // clock cycles per latency unit
  parameter int HIT_U    = 2,
  parameter int EMPTY_U  = 4,
  parameter int CONF_U   = 6,
  parameter int PRE_U    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             close_page_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             done_o,
  output logic [TAG_W-1:0] done_tag_o,
  output logic [COL_W-1:0] done_col_o,
  output logic             done_hit_o,
  output logic             done_conf_o
);

  localparam int HIT_CYC   = HIT_U   * UNIT_CYC;
  localparam int EMPTY_CYC = EMPTY_U * UNIT_CYC;
  localparam int CONF_CYC  = CONF_U  * UNIT_CYC;
  localparam int PRE_CYC   = PRE_U   * UNIT_CYC;
  localparam int MAX_A     = (HIT_CYC > EMPTY_CYC) ? HIT_CYC : EMPTY_CYC;
  localparam int MAX_B     = (CONF_CYC > PRE_CYC) ? CONF_CYC : PRE_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  bank_st_e         state_q, state_d;
  acc_kind_e        kind;
  logic             cnt_zero, cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             acc_end, pre_end, accept;

  acc_kind_e        fl_kind_q;
  logic [TAG_W-1:0] fl_tag_q;
  logic [COL_W-1:0] fl_col_q;

  assign acc_end = (state_q == ST_ACCESS) && cnt_zero;
  assign pre_end = (state_q == ST_PRECH)  && cnt_zero;

  // accept in the edge that ends the previous work: no bubble
  assign req_ready_o = (state_q == ST_IDLE) || (acc_end && !close_page_i) || pre_end;
  assign accept      = req_valid_i && req_ready_o;

  dbt_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk_i,
    .rst_ni,
    .open_i        (accept),
    .row_i         (req_row_i),
    .close_i       (pre_end),
    .force_empty_i (state_q == ST_PRECH),
    .kind_o        (kind)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept) begin
      cnt_load = 1'b1;
      unique case (kind)
        ACC_HIT:  cnt_val = CNT_W'(HIT_CYC - 1);
        ACC_CONF: cnt_val = CNT_W'(CONF_CYC - 1);
        default:  cnt_val = CNT_W'(EMPTY_CYC - 1);
      endcase
    end else if (acc_end && close_page_i) begin
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(PRE_CYC - 1);
    end
  end

  dbt_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i,
    .rst_ni,
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    state_d = state_q;
    if (accept)       state_d = ST_ACCESS;
    else if (acc_end) state_d = close_page_i ? ST_PRECH : ST_IDLE;
    else if (pre_end) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fl_kind_q <= ACC_EMPTY;
      fl_tag_q  <= '0;
      fl_col_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        fl_kind_q <= kind;
        fl_tag_q  <= req_tag_i;
        fl_col_q  <= req_col_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      done_tag_o  <= '0;
      done_col_o  <= '0;
      done_hit_o  <= 1'b0;
      done_conf_o <= 1'b0;
    end else begin
      done_o <= acc_end;
      if (acc_end) begin
        done_tag_o  <= fl_tag_q;
        done_col_o  <= fl_col_q;
        done_hit_o  <= (fl_kind_q == ACC_HIT);
        done_conf_o <= (fl_kind_q == ACC_CONF);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R9

  AST_CLOSE_ALWAYS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_page_i && done_o) |-> (!done_hit_o && !done_conf_o)); // R6

  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(done_hit_o && done_conf_o)); // R4

  generate
    if (PRE_CYC > 1) begin : g_pre_chk
      AST_PRECH_HOLDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_page_i && done_o) |-> !req_ready_o); // R6
    end
  endgenerate

endmodule

// File: tb/dram_bank_timer_test.sv
module dram_bank_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       close_page = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic [3:0] req_tag = '0;
  logic       done;
  logic [3:0] done_tag;
  logic [5:0] done_col;
  logic       done_hit, done_conf;

  always #5 clk = ~clk;

  dram_bank_timer #(.ROW_W(8), .COL_W(6), .TAG_W(4), .UNIT_CYC(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .close_page_i(close_page),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .req_tag_i(req_tag),
    .done_o(done), .done_tag_o(done_tag), .done_col_o(done_col),
    .done_hit_o(done_hit), .done_conf_o(done_conf)
  );

  // X row 5, Y row 9; kind: 0 empty, 1 hit, 2 conflict; times in ns (1 cycle = 10 ns)
  localparam int ARR_NS   [6] = '{0, 10, 100, 200, 250, 300};
  localparam int ROW_V    [6] = '{5, 9, 5, 5, 9, 5};
  localparam int COL_V    [6] = '{1, 2, 3, 4, 5, 6};
  localparam int OPEN_NS  [6] = '{40, 100, 160, 220, 310, 370};
  localparam int OPEN_K   [6] = '{0, 2, 2, 1, 2, 2};
  localparam int CLOSE_NS [6] = '{40, 100, 160, 240, 300, 360};

  int n_chk = 0, n_fail = 0;
  int cyc;
  int d_cyc [16];
  int d_kind[16];
  int d_col [16];
  int n_done;
  logic prev_done;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R8 pulse width", 2, 1);
      prev_done = done;
      if (done) begin
        d_cyc[done_tag]  = cyc;
        d_kind[done_tag] = done_hit ? 1 : (done_conf ? 2 : 0);
        d_col[done_tag]  = int'(done_col);
        n_done++;
      end
    end
  end

  task automatic apply_reset(input bit cp);
    rst_n = 1'b0;
    req_valid = 1'b0;
    close_page = cp;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      d_cyc[i] = -1; d_kind[i] = -1; d_col[i] = -1;
    end
    n_done = 0;
    prev_done = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic send(input int arr, input int row, input int col, input int tag);
    while (cyc < arr - 1) @(negedge clk);
    req_valid = 1'b1;
    req_row = 8'(row);
    req_col = 6'(col);
    req_tag = 4'(tag);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (n_done < n && t < 500) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(n_done == n, "R9 completion count", n_done, n);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    apply_reset(1'b0);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    // open-page pattern: R2 R3 R4 R5 R7
    for (int i = 0; i < 6; i++) send(ARR_NS[i] / 10, ROW_V[i], COL_V[i], i);
    wait_done(6);
    for (int i = 0; i < 6; i++) begin
      chk(d_cyc[i] * 10 == OPEN_NS[i], "R2 R3 R4 R7 open finish ns", d_cyc[i] * 10, OPEN_NS[i]);
      chk(d_kind[i] == OPEN_K[i], "R5 open class", d_kind[i], OPEN_K[i]);
      chk(d_col[i] == COL_V[i], "R8 column echo", d_col[i], COL_V[i]);
    end

    // close-page pattern: R6 R7
    apply_reset(1'b1);
    for (int i = 0; i < 6; i++) send(ARR_NS[i] / 10, ROW_V[i], COL_V[i], i);
    wait_done(6);
    for (int i = 0; i < 6; i++) begin
      chk(d_cyc[i] * 10 == CLOSE_NS[i], "R6 R7 close finish ns", d_cyc[i] * 10, CLOSE_NS[i]);
      chk(d_kind[i] == 0, "R6 close class", d_kind[i], 0);
    end

    // back-to-back hit, open page: R1 R3 R8
    apply_reset(1'b0);
    send(0, 3, 7, 1);
    send(1, 3, 8, 2);
    wait_done(2);
    chk(d_cyc[1] == 4 && d_kind[1] == 0, "R1 first access empty", d_cyc[1], 4);
    chk(d_cyc[2] == 6, "R3 hit finish", d_cyc[2], 6);
    chk(d_kind[2] == 1, "R3 hit class", d_kind[2], 1);
    chk(d_col[2] == 8, "R8 column of hit", d_col[2], 8);

    // ready around the close-page precharge: R6 R8 R9
    apply_reset(1'b1);
    req_valid = 1'b1; req_row = 8'd4; req_col = 6'd1; req_tag = 4'd3;
    @(negedge clk);           // cyc 0: accepted
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
    while (cyc < 4) @(negedge clk);
    chk(done == 1'b1 && done_tag == 4'd3, "R8 done with tag", int'(done_tag), 3);
    chk(req_ready == 1'b0, "R6 ready low in precharge", int'(req_ready), 0);
    @(negedge clk);           // cyc 5
    chk(done == 1'b0, "R8 done drops", int'(done), 0);
    chk(req_ready == 1'b1, "R6 ready after precharge", int'(req_ready), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule